// File: doc/BRIEF.md
# Audio Link Output Frame Deserializer

This block is the receiving end of the serial output stream that a controller sends to a codec. It runs on the edge at which the codec samples the link, the falling edge of the bit clock, with that clock inverted at the chip boundary. On each of these edges it samples the frame marker and the serial data line. It finds frame starts and shifts in each 256-bit frame. A frame holds a 16-bit tag word, then twelve 20-bit payload slots, and every field arrives most significant bit first.

The block reports the tag word once per frame, as soon as its last bit is in. It then reports each payload slot with its index and a single validity flag. In primary mode, slot validity comes straight from the tag. In secondary mode, the two command slots are validated another way: the low two tag bits must match the configured codec identifier, and for the data slot, the top bit of the address slot must also be set. If a new frame marker arrives before the current frame has finished, the partial frame is dropped, an error pulse is raised and reception starts again.

Top module: `link_out_deser`

## Requirements
- R1: While reset is asserted and on the first sample after its release, tagStrobe, slotStrobe, slotValid and frameError are all 0.
- R2: A frame begins at the sample where syncIn is 1 and was 0 at the previous sample. The first tag bit (bit 15) is the sdoIn value at the very next sample.
- R3: The 16 tag bits are received MSB first. On the sample after the 16th tag bit, tagWord holds them and tagStrobe is 1 for exactly one cycle.
- R4: Slots 1 to 12 each follow as 20 bits, MSB first. On the sample after a slot's last bit, slotData holds the slot, slotIdx holds its number and slotStrobe is 1 for one cycle. Slots are reported once each and in ascending order. slotValid is only ever 1 together with slotStrobe.
- R5: When tag bit 15 (frame valid) is 0, slotValid stays 0 for every slot of that frame.
- R6: Slots 3 to 12 are valid in either mode when tag bit (15 − slot number) is 1. In primary mode (secondaryMode = 0), slot 1 is validated by tag bit 14, slot 2 by tag bit 13, and tag bits 1:0 have no effect.
- R7: In secondary mode, tag bits 14 and 13 have no effect. Slot 1 is valid exactly when tag bits 1:0 equal codecId.
- R8: In secondary mode, slot 2 is valid exactly when tag bits 1:0 equal codecId and bit 19 of that frame's slot 1 is 1.
- R9: A frame-marker rise before the 256th bit of the current frame makes frameError 1 for one cycle on the next sample. No tag or slot strobe comes from the bit sampled at that edge. The new frame is then received normally.
- R10: A frame-marker rise on the same sample as the 256th bit completes slot 12 normally, raises no error and starts the next frame. A rise after a frame has finished also raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (inverted link bit clock) |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Frame marker line |
| sdoIn | input | 1 | Serial output-frame data line |
| secondaryMode | input | 1 | 1 selects secondary-codec command validation |
| codecId | input | 2 | Codec identifier matched against tag bits 1:0 |
| tagWord | output | 16 | Last received tag word |
| tagStrobe | output | 1 | One-cycle pulse when tagWord is updated |
| slotData | output | 20 | Last received payload slot |
| slotIdx | output | 4 | Number (1 to 12) of the slot in slotData |
| slotStrobe | output | 1 | One-cycle pulse when a slot is complete |
| slotValid | output | 1 | Validity of the slot reported with slotStrobe |
| frameError | output | 1 | One-cycle pulse on a truncated frame |

## Verification
In primary mode, frames are sent back to back with walking-one, all-ones and alternating validity patterns, with random identifier bits, and with the frame-valid bit cleared. This shows whether each slot reads its own tag bit and whether the frame-valid gate works. Secondary mode is swept over every combination of codecId, tag identifier bits and the slot-1 top bit, with tag bits 14 and 13 set arbitrarily. This separates identifier matching from tag-bit validation. Frames truncated inside slot 1 and exactly on a slot boundary, followed by clean frames, show the difference between an abort and a normal frame end. Continuous streams with no gap between frames test the case where the marker rise and the final bit land on the same sample.

// File: rtl/link_out_pkg.sv
package link_out_pkg;
  // Per-edge commands from the control to the datapath
  typedef struct packed {
    logic shiftEn;   // take sdoIn into the shift register
    logic loadTag;   // current bit completes the tag word
    logic loadSlot;  // current bit completes a payload slot
  } ctlStrobe_t;
endpackage

// File: rtl/link_out_ctrl.sv
module link_out_ctrl
  import link_out_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  parameter int IDX_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  output ctlStrobe_t       strobe,
  output logic [IDX_W-1:0] slotNum,
  output logic             frameError
);
  localparam int MAX_LEN = (SLOT_BITS > TAG_BITS) ? SLOT_BITS : TAG_BITS;
  localparam int POS_W   = $clog2(MAX_LEN);

  logic             syncPrev;
  logic             active;
  logic [POS_W-1:0] bitPos;
  logic [IDX_W-1:0] slotCnt;
  logic             syncRise;
  logic             lastBit;
  logic             finalBit;
  logic             abort;

  assign syncRise = syncIn & ~syncPrev;

  always_comb begin
    if (slotCnt == '0) lastBit = active && (bitPos == POS_W'(TAG_BITS - 1));
    else               lastBit = active && (bitPos == POS_W'(SLOT_BITS - 1));
    finalBit = lastBit && (slotCnt == IDX_W'(NUM_SLOTS));
    abort    = syncRise && active && !finalBit;
    strobe.shiftEn  = active;
    strobe.loadTag  = lastBit && (slotCnt == '0) && !abort;
    strobe.loadSlot = lastBit && (slotCnt != '0) && !abort;
  end

  assign slotNum = slotCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev   <= 1'b0;
      active     <= 1'b0;
      bitPos     <= '0;
      slotCnt    <= '0;
      frameError <= 1'b0;
    end else begin
      syncPrev   <= syncIn;
      frameError <= abort;
      if (syncRise) begin
        active  <= 1'b1;
        bitPos  <= '0;
        slotCnt <= '0;
      end else if (active) begin
        if (lastBit) begin
          bitPos <= '0;
          if (finalBit) active  <= 1'b0;
          else          slotCnt <= slotCnt + 1'b1;
        end else begin
          bitPos <= bitPos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/link_out_dpath.sv
module link_out_dpath
  import link_out_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ID_BITS   = 2,
  parameter int IDX_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdoIn,
  input  ctlStrobe_t           strobe,
  input  logic [IDX_W-1:0]     slotNum,
  input  logic                 secondaryMode,
  input  logic [ID_BITS-1:0]   codecId,
  output logic [TAG_BITS-1:0]  tagWord,
  output logic                 tagStrobe,
  output logic [SLOT_BITS-1:0] slotData,
  output logic [IDX_W-1:0]     slotIdx,
  output logic                 slotStrobe,
  output logic                 slotValid
);
  localparam int EN_W = 1 << IDX_W;

  logic [SLOT_BITS-1:0] shiftReg;
  logic [SLOT_BITS-1:0] nextWord;
  logic                 addrMsb;
  logic [EN_W-1:0]      tagEn;
  logic                 idMatch;
  logic                 validNow;

  assign nextWord = {shiftReg[SLOT_BITS-2:0], sdoIn};
  assign idMatch  = (tagWord[ID_BITS-1:0] == codecId);

  // Tag bit that validates each slot number; unused numbers read 0
  for (genvar n = 0; n < EN_W; n++) begin : g_en
    if (n >= 1 && n <= NUM_SLOTS) begin : g_on
      assign tagEn[n] = tagWord[TAG_BITS-1-n];
    end else begin : g_off
      assign tagEn[n] = 1'b0;
    end
  end

  always_comb begin
    validNow = 1'b0;
    if (tagWord[TAG_BITS-1]) begin
      if (secondaryMode && slotNum == IDX_W'(1))      validNow = idMatch;
      else if (secondaryMode && slotNum == IDX_W'(2)) validNow = idMatch && addrMsb;
      else                                            validNow = tagEn[slotNum];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      tagWord    <= '0;
      tagStrobe  <= 1'b0;
      slotData   <= '0;
      slotIdx    <= '0;
      slotStrobe <= 1'b0;
      slotValid  <= 1'b0;
      addrMsb    <= 1'b0;
    end else begin
      tagStrobe  <= strobe.loadTag;
      slotStrobe <= strobe.loadSlot;
      slotValid  <= strobe.loadSlot && validNow;
      if (strobe.shiftEn) shiftReg <= nextWord;
      if (strobe.loadTag) tagWord <= nextWord[TAG_BITS-1:0];
      if (strobe.loadSlot) begin
        slotData <= nextWord;
        slotIdx  <= slotNum;
        if (slotNum == IDX_W'(1)) addrMsb <= nextWord[SLOT_BITS-1];
      end
    end
  end
endmodule

// File: rtl/link_out_deser.sv
module link_out_deser
  import link_out_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ID_BITS   = 2,
  parameter int IDX_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 syncIn,
  input  logic                 sdoIn,
  input  logic                 secondaryMode,
  input  logic [ID_BITS-1:0]   codecId,
  output logic [TAG_BITS-1:0]  tagWord,
  output logic                 tagStrobe,
  output logic [SLOT_BITS-1:0] slotData,
  output logic [IDX_W-1:0]     slotIdx,
  output logic                 slotStrobe,
  output logic                 slotValid,
  output logic                 frameError
);
  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] slotNum;

  link_out_ctrl #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS),
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn),
    .strobe(strobe), .slotNum(slotNum), .frameError(frameError)
  );

  link_out_dpath #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS),
    .ID_BITS(ID_BITS), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .sdoIn(sdoIn), .strobe(strobe),
    .slotNum(slotNum), .secondaryMode(secondaryMode), .codecId(codecId),
    .tagWord(tagWord), .tagStrobe(tagStrobe), .slotData(slotData),
    .slotIdx(slotIdx), .slotStrobe(slotStrobe), .slotValid(slotValid)
  );
endmodule

// File: rtl/link_out_deser_chk.sv
module link_out_deser_chk #(
  parameter int TAG_BITS  = 16,
  parameter int NUM_SLOTS = 12,
  parameter int ID_BITS   = 2,
  parameter int IDX_W     = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                secondaryMode,
  input logic [ID_BITS-1:0]  codecId,
  input logic [TAG_BITS-1:0] tagWord,
  input logic                tagStrobe,
  input logic [IDX_W-1:0]    slotIdx,
  input logic                slotStrobe,
  input logic                slotValid,
  input logic                frameError
);
  // R9: an aborting edge yields no strobe, so the three pulses never coincide
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tagStrobe, slotStrobe, frameError}));

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameError |=> !frameError);

  assert_tag_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    tagStrobe |=> !tagStrobe && !slotStrobe);

  assert_slot_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    slotStrobe |=> !slotStrobe);

  assert_valid_with_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |-> slotStrobe);

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    slotStrobe |-> (slotIdx >= IDX_W'(1)) && (slotIdx <= IDX_W'(NUM_SLOTS)));

  assert_frame_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (slotStrobe && !tagWord[TAG_BITS-1]) |-> !slotValid);

  assert_sec_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (slotStrobe && secondaryMode && slotIdx == IDX_W'(1) &&
     tagWord[ID_BITS-1:0] != codecId) |-> !slotValid);

  assert_sec_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (slotStrobe && secondaryMode && slotIdx == IDX_W'(2) &&
     tagWord[ID_BITS-1:0] != codecId) |-> !slotValid);
endmodule

bind link_out_deser link_out_deser_chk #(
  .TAG_BITS(TAG_BITS), .NUM_SLOTS(NUM_SLOTS), .ID_BITS(ID_BITS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .secondaryMode(secondaryMode), .codecId(codecId),
  .tagWord(tagWord), .tagStrobe(tagStrobe), .slotIdx(slotIdx),
  .slotStrobe(slotStrobe), .slotValid(slotValid), .frameError(frameError)
);

// File: tb/tb_link_out_deser.sv
module tb_link_out_deser;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, syncIn, sdoIn, secondaryMode;
  logic [1:0]  codecId;
  logic [15:0] tagWord;
  logic        tagStrobe, slotStrobe, slotValid, frameError;
  logic [19:0] slotData;
  logic [3:0]  slotIdx;

  link_out_deser dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .sdoIn(sdoIn),
    .secondaryMode(secondaryMode), .codecId(codecId), .tagWord(tagWord),
    .tagStrobe(tagStrobe), .slotData(slotData), .slotIdx(slotIdx),
    .slotStrobe(slotStrobe), .slotValid(slotValid), .frameError(frameError)
  );

  int checks = 0, errors = 0;

  // recorded output events
  logic [15:0] gotTag;
  logic [19:0] gotData [1:12];
  logic        gotValid [1:12];
  int tagSeen = 0, slotSeen = 0, errSeen = 0, orderBad = 0, lastIdx = 0;

  // expectations for the frame whose results are still arriving
  bit          pendActive = 0, pendSec;
  logic [15:0] pendTag;
  logic [1:0]  pendId;
  logic [19:0] pendData [1:12];
  int          pendTags, pendSlots, pendErr;

  bit   carryValid = 0;
  logic carryBit = 1'b0;

  always @(posedge clk) begin
    #2;
    if (rstN) begin
      if (tagStrobe) begin tagSeen++; gotTag = tagWord; end
      if (frameError) errSeen++;
      if (slotStrobe) begin
        slotSeen++;
        if (int'(slotIdx) != lastIdx + 1) orderBad++;
        lastIdx = int'(slotIdx);
        if (slotIdx >= 1 && slotIdx <= 12) begin
          gotData[slotIdx]  = slotData;
          gotValid[slotIdx] = slotValid;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] slotVal(int seed, int n, logic msb);
    logic [19:0] v;
    if (seed == 1)      v = 20'hFFFFF;
    else if (seed == 2) v = 20'h00000;
    else                v = 20'(seed * 40503 + n * 91173 + 12345);
    if (n == 1) v[19] = msb;
    return v;
  endfunction

  function automatic bit expValid(logic [15:0] t, bit sec, logic [1:0] id,
                                  logic s1msb, int n);
    if (!t[15]) return 0;
    if (sec && n == 1) return t[1:0] == id;
    if (sec && n == 2) return (t[1:0] == id) && s1msb;
    return t[15-n];
  endfunction

  task automatic drive(input logic s, input logic d);
    @(negedge clk);
    syncIn = s;
    sdoIn  = d;
  endtask

  task automatic clearRecord();
    tagSeen = 0; slotSeen = 0; errSeen = 0; orderBad = 0; lastIdx = 0;
  endtask

  task automatic checkPending();
    if (pendActive) begin
      chk(tagSeen == pendTags, "R3", "tag strobe count", tagSeen, pendTags);
      if (pendTags == 1 && tagSeen == 1)
        chk(gotTag == pendTag, "R2", "tag word alignment", gotTag, pendTag);
      chk(slotSeen == pendSlots, pendErr ? "R9" : "R4", "slot strobe count",
          slotSeen, pendSlots);
      chk(orderBad == 0, "R4", "slot order", orderBad, 0);
      chk(errSeen == pendErr, pendErr ? "R9" : "R10", "frame error count",
          errSeen, pendErr);
      for (int n = 1; n <= pendSlots && n <= slotSeen; n++) begin
        bit ev;
        string rq;
        ev = expValid(pendTag, pendSec, pendId, pendData[1][19], n);
        if (!pendTag[15])              rq = "R5";
        else if (pendSec && n == 1)    rq = "R7";
        else if (pendSec && n == 2)    rq = "R8";
        else                           rq = "R6";
        chk(gotData[n] == pendData[n], "R4", $sformatf("slot %0d data", n),
            gotData[n], pendData[n]);
        chk(gotValid[n] == ev, rq, $sformatf("slot %0d valid", n),
            gotValid[n], ev);
      end
    end
    clearRecord();
    pendActive = 0;
  endtask

  // Sends one frame; stopAt < 256 truncates it after stopAt bits
  task automatic runFrame(input logic [15:0] tag, input bit sec,
                          input logic [1:0] id, input logic s1msb,
                          input int seed, input int stopAt);
    logic fb [0:255];
    logic [19:0] dv [1:12];
    for (int j = 0; j < 16; j++) fb[15-j] = tag[j];
    for (int n = 1; n <= 12; n++) begin
      dv[n] = slotVal(seed, n, s1msb);
      for (int b = 0; b < 20; b++) fb[16 + 20*(n-1) + (19-b)] = dv[n][b];
    end
    secondaryMode = sec;
    codecId       = id;
    drive(1'b1, carryValid ? carryBit : 1'b0);   // R2: marker rise edge
    drive(1'b1, fb[0]);
    checkPending();
    for (int i = 1; i < stopAt && i < 255; i++) drive(i < 15, fb[i]);
    pendActive = 1;
    pendSec    = sec;
    pendTag    = tag;
    pendId     = id;
    for (int n = 1; n <= 12; n++) pendData[n] = dv[n];
    if (stopAt >= 256) begin
      pendTags = 1; pendSlots = 12; pendErr = 0;
      carryValid = 1; carryBit = fb[255];
    end else begin
      pendTags  = (stopAt >= 16) ? 1 : 0;
      pendSlots = 0;
      for (int n = 1; n <= 12; n++) if (15 + 20*n <= stopAt - 1) pendSlots++;
      pendErr    = 1;
      carryValid = 0;
    end
  endtask

  task automatic finishStream();
    drive(1'b0, carryValid ? carryBit : 1'b0);
    drive(1'b0, 1'b0);
    checkPending();
    carryValid = 0;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; syncIn = 1'b0; sdoIn = 1'b0; secondaryMode = 1'b0; codecId = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!tagStrobe && !slotStrobe && !slotValid && !frameError, "R1",
        "strobes in reset", {tagStrobe, slotStrobe, slotValid, frameError}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!tagStrobe && !slotStrobe && !slotValid && !frameError, "R1",
        "strobes after release", {tagStrobe, slotStrobe, slotValid, frameError}, 0);

    // R6 R5 R10: primary sweep, continuous stream
    for (int k = 0; k < 15; k++) begin
      logic [11:0] pat;
      logic        fv;
      if (k < 12)       pat = 12'(1 << (11 - k));
      else if (k == 12) pat = 12'hFFF;
      else              pat = 12'hAAA;
      fv = (k != 7 && k != 14);
      if (k == 14) pat = 12'hFFF;
      runFrame({fv, pat, 1'b0, 2'(k)}, 1'b0, 2'(k + 1), 1'(k), k % 3 == 0 ? 1 : k + 3, 256);
    end
    finishStream();
    repeat (5) drive(1'b0, 1'b0);

    // R7 R8: secondary sweep over id, tag id bits and slot 1 top bit
    for (int id = 0; id < 4; id++)
      for (int tid = 0; tid < 4; tid++)
        for (int m = 0; m < 2; m++) begin
          logic [9:0] pat;
          pat = 10'(id * 83 + tid * 29 + m * 7);
          runFrame({1'b1, 1'(tid), 1'(id + m), pat, 1'b0, 2'(tid)}, 1'b1,
                   2'(id), 1'(m), id * 8 + tid * 2 + m + 4, 256);
        end
    finishStream();

    // R9: truncation on a slot boundary, then inside slot 1
    runFrame(16'hFFF8, 1'b0, 2'd0, 1'b1, 2, 256);
    runFrame(16'hFFF8, 1'b0, 2'd0, 1'b1, 5, 115);
    runFrame(16'hE5A8, 1'b0, 2'd0, 1'b0, 6, 256);
    runFrame(16'hFFF8, 1'b1, 2'd0, 1'b1, 7, 20);
    runFrame(16'hFFF8, 1'b1, 2'd0, 1'b1, 8, 256);
    finishStream();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule